// File: doc/BRIEF.md
# Master Clock Rate Selector and Frame Divider

This block decides how a voice codec interprets its master clock and produces the internal frame timing from it. A rate-select pin is watched for activity. If it keeps toggling, it is taken to be a receive bit clock, and the codec runs with independent receive timing. If it sits still, its level is latched and picks one of the supported master clock rates.

The block then divides the transmit master clock, delivered as a one-cycle enable, down to a single strobe per 8 kHz frame. In the 1.544 MHz rate, every frame carries one master clock pulse too many. The divider drops that pulse at a fixed place counted from the transmit frame sync. A second activity watcher on the receive master clock pin decides whether receive timing runs from its own master clock or borrows the transmit one.

A parameter selects the part family. The narrow family supports 1.536 and 1.544 MHz. The wide family supports 1.536 and 2.048 MHz.

Top module: `mclk_sel_div`

## Requirements
- R1: After reset, `frame_tick`, `rx_mclk_own` and `rx_bclk_own` are 0. `div_mode` is 0 for the narrow family and 2 for the wide family. Mode codes are: 0 for 1.536 MHz (divide by 192), 1 for 1.544 MHz (193 pulses with one dropped), 2 for 2.048 MHz (divide by 256).
- R2: Pins are sampled on each `mclk_tx_en` pulse. The first sample after reset only primes the watcher. A change of `sel_pin` between two successive samples sets `rx_bclk_own` to 1 by the next falling clock edge.
- R3: `rx_bclk_own` falls after the ACT_WIN-th consecutive sample with no change of `sel_pin`, and not after ACT_WIN-1 such samples.
- R4: Narrow family mapping. A static 0 on `sel_pin` gives mode 1. A static 1, a toggling pin, or a pin not yet judged gives mode 0.
- R5: In mode 0, `frame_tick` is high during the 192nd accepted `mclk_tx_en` pulse after a frame sync and then every 192 pulses. It is only ever high together with `mclk_tx_en`.
- R6: Wide family mapping. A static 0 gives mode 0, and anything else gives mode 2. In mode 2, the strobe comes on the 256th pulse after a frame sync and then every 256 pulses.
- R7: In mode 1, the pulse at position SKIP_POS of each 193-pulse frame is ignored. Positions start at 0 with the first pulse after the frame sync. With SKIP_POS = 192, strobes fall on pulses 192, 385 and 578 after the frame sync.
- R8: `fsx_pulse` restarts both the frame count and the drop position. A master clock pulse in the same cycle as `fsx_pulse` counts as pulse 1 of the new frame.
- R9: `rx_mclk_own` becomes 1 once `rx_mclk_pin` changes between samples. It falls back to 0 after ACT_WIN consecutive unchanged samples. At 0, receive timing borrows the transmit master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_tx_en | input | 1 | One-cycle enable per transmit master clock period |
| rx_mclk_pin | input | 1 | Sampled receive master clock pin |
| sel_pin | input | 1 | Sampled rate-select / receive bit clock pin |
| fsx_pulse | input | 1 | One-cycle transmit frame sync |
| div_mode | output | 2 | Selected divider mode code |
| rx_mclk_own | output | 1 | 1: receive side uses its own master clock |
| rx_bclk_own | output | 1 | 1: select pin is the receive bit clock (independent timing) |
| frame_tick | output | 1 | Internal frame-rate strobe |

## Verification
A frame sync can arrive in the same cycle as a master clock pulse. The restart then competes with the count advance and the drop-position step. The bench provokes this by raising `fsx_pulse` and `mclk_tx_en` together in 1.544 MHz mode. It then counts pulses, including the shared one, and expects the strobe on exactly the 192nd. Both family variants are driven from the same pins, so one stimulus checks both mode mappings at the same moment.

// File: rtl/mclk_sel_pkg.sv
package mclk_sel_pkg;

    localparam int DIV_NARROW = 192;
    localparam int DIV_WIDE   = 256;
    localparam int FRAME_LONG = 193;
    localparam int CNT_W      = $clog2(DIV_WIDE);

    typedef enum logic [1:0] {
        DIV_1536 = 2'd0,
        DIV_1544 = 2'd1,
        DIV_2048 = 2'd2
    } div_mode_e;

    typedef struct packed {
        logic valid;
        logic active;
        logic level;
    } pin_stat_t;

    function automatic div_mode_e pick_mode(input logic wide, input pin_stat_t st);
        logic static_low;
        static_low = st.valid && !st.active && !st.level;
        if (wide)
            return static_low ? DIV_1536 : DIV_2048;
        else
            return static_low ? DIV_1544 : DIV_1536;
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input div_mode_e m);
        return (m == DIV_2048) ? CNT_W'(DIV_WIDE - 1) : CNT_W'(DIV_NARROW - 1);
    endfunction

endpackage

// File: rtl/mclk_act_det.sv
module mclk_act_det
    import mclk_sel_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sample_en,
    input  logic      pin,
    output pin_stat_t stat
);
    localparam int TW = $clog2(WIN + 1);

    logic          prev;
    logic          primed;
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            primed <= 1'b0;
            timer  <= '0;
            stat   <= '0;
        end else if (sample_en) begin
            prev   <= pin;
            primed <= 1'b1;
            if (!primed) begin
                timer <= '0;
            end else if (pin != prev) begin
                stat.active <= 1'b1;
                stat.valid  <= 1'b1;
                timer       <= '0;
            end else if (timer == TW'(WIN - 1)) begin
                stat.active <= 1'b0;
                stat.valid  <= 1'b1;
                stat.level  <= pin;
                timer       <= '0;
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    AST_EDGE_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (sample_en && primed && pin != prev) |=> stat.active) else $error("edge lost"); // R2

    AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(stat)) else $error("state moved without sample"); // R3

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        timer < TW'(WIN)) else $error("timer overrun"); // R3

endmodule

// File: rtl/mclk_frame_div.sv
module mclk_frame_div
    import mclk_sel_pkg::*;
#(
    parameter int SKIP_POS = FRAME_LONG - 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_en,
    input  logic      fsync,
    input  div_mode_e mode,
    output logic      tick
);
    localparam int PW = $clog2(FRAME_LONG);

    logic [CNT_W-1:0] cnt, cnt_eff, lim;
    logic [PW-1:0]    pos, pos_eff;
    logic             skip;

    always_comb begin
        pos_eff = fsync ? '0 : pos;
        cnt_eff = fsync ? '0 : cnt;
        lim     = last_count(mode);
        skip    = (mode == DIV_1544) && (pos_eff == PW'(SKIP_POS));
        tick    = tick_en && !skip && (cnt_eff >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            pos <= '0;
        end else if (tick_en) begin
            pos <= (pos_eff == PW'(FRAME_LONG - 1)) ? '0 : pos_eff + 1'b1;
            if (skip)
                cnt <= cnt_eff;
            else
                cnt <= (cnt_eff >= lim) ? '0 : cnt_eff + 1'b1;
        end else begin
            pos <= pos_eff;
            cnt <= cnt_eff;
        end
    end

    AST_TICK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |-> tick_en) else $error("strobe without pulse"); // R5

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == '0) else $error("count not wrapped"); // R5

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos < PW'(FRAME_LONG)) else $error("drop position overrun"); // R7

    AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        fsync |=> cnt <= CNT_W'(1)) else $error("frame sync ignored"); // R8

endmodule

// File: rtl/mclk_sel_div.sv
module mclk_sel_div
    import mclk_sel_pkg::*;
#(
    parameter bit FAMILY_WIDE = 1'b0,
    parameter int ACT_WIN     = 16,
    parameter int SKIP_POS    = FRAME_LONG - 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_tx_en,
    input  logic       rx_mclk_pin,
    input  logic       sel_pin,
    input  logic       fsx_pulse,
    output logic [1:0] div_mode,
    output logic       rx_mclk_own,
    output logic       rx_bclk_own,
    output logic       frame_tick
);
    pin_stat_t sel_stat;
    pin_stat_t rx_stat;
    div_mode_e mode;
    logic      unused_rx_level;

    mclk_act_det #(.WIN(ACT_WIN)) u_sel_det (
        .clk       (clk),
        .rst       (rst),
        .sample_en (mclk_tx_en),
        .pin       (sel_pin),
        .stat      (sel_stat)
    );

    mclk_act_det #(.WIN(ACT_WIN)) u_rx_det (
        .clk       (clk),
        .rst       (rst),
        .sample_en (mclk_tx_en),
        .pin       (rx_mclk_pin),
        .stat      (rx_stat)
    );

    always_comb begin
        mode            = pick_mode(FAMILY_WIDE, sel_stat);
        div_mode        = mode;
        rx_bclk_own     = sel_stat.valid && sel_stat.active;
        rx_mclk_own     = rx_stat.valid && rx_stat.active;
        unused_rx_level = rx_stat.level;
    end

    mclk_frame_div #(.SKIP_POS(SKIP_POS)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick_en (mclk_tx_en),
        .fsync   (fsx_pulse),
        .mode    (mode),
        .tick    (frame_tick)
    );

    AST_CLOCKED_NOT_1544: assert property (@(posedge clk) disable iff (rst)
        rx_bclk_own |-> div_mode != 2'd1) else $error("clocked pin gave 1544"); // R4

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        div_mode != 2'd3) else $error("illegal mode"); // R6

endmodule

// File: tb/mclk_sel_div_tb.sv
module mclk_sel_div_tb;
    localparam int WIN = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk_en = 1'b0, rx_pin = 1'b0, sel = 1'b0, fsx = 1'b0;
    logic [1:0] mode_n, mode_w;
    logic rxm_n, rxb_n, tick_n, rxm_w, rxb_w, tick_w;

    int n_chk = 0, n_bad = 0, pcount = 0;
    int ta[8], tb_[8];
    int na = 0, nb = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mclk_sel_div #(.FAMILY_WIDE(1'b0), .ACT_WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .mclk_tx_en(mclk_en), .rx_mclk_pin(rx_pin),
        .sel_pin(sel), .fsx_pulse(fsx), .div_mode(mode_n),
        .rx_mclk_own(rxm_n), .rx_bclk_own(rxb_n), .frame_tick(tick_n));

    mclk_sel_div #(.FAMILY_WIDE(1'b1), .ACT_WIN(WIN)) u_dut_w (
        .clk(clk), .rst(rst), .mclk_tx_en(mclk_en), .rx_mclk_pin(rx_pin),
        .sel_pin(sel), .fsx_pulse(fsx), .div_mode(mode_w),
        .rx_mclk_own(rxm_w), .rx_bclk_own(rxb_w), .frame_tick(tick_w));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        pcount = 0; na = 0; nb = 0;
        for (int i = 0; i < 8; i++) begin ta[i] = 0; tb_[i] = 0; end
    endtask

    task automatic step(input logic s, input logic r, input logic f, input logic e);
        @(negedge clk);
        sel = s; rx_pin = r; fsx = f; mclk_en = e;
        if (e) pcount++;
        #1;
        if (tick_n) begin if (na < 8) ta[na] = pcount; na++; end
        if (tick_w) begin if (nb < 8) tb_[nb] = pcount; nb++; end
        if ((tick_n || tick_w) && !e) check("R5 strobe without pulse", 1, 0);
        @(negedge clk);
        mclk_en = 0; fsx = 0;
    endtask

    task automatic t_reset();
        check("R1 narrow mode", mode_n, 0);
        check("R1 wide mode", mode_w, 2);
        check("R1 rx_mclk_own", rxm_n, 0);
        check("R1 rx_bclk_own", rxb_n, 0);
        check("R1 frame_tick", tick_n, 0);
    endtask

    task automatic t_static_low();
        for (int i = 0; i < WIN + 4; i++) step(0, 0, 0, 1);
        check("R4 static0 narrow -> 1544", mode_n, 1);
        check("R6 static0 wide -> 1536", mode_w, 0);
        check("R3 static sel not clocked", rxb_n, 0);
        check("R9 static rx pin borrows tx", rxm_n, 0);
    endtask

    task automatic t_1544_frames();
        step(0, 0, 1, 0);
        clear_log();
        for (int i = 0; i < 600; i++) step(0, 0, 0, 1);
        check("R7 tick count 1544", na, 3);
        check("R7 first tick", ta[0], 192);
        check("R7 second tick after drop", ta[1], 385);
        check("R7 third tick", ta[2], 578);
        check("R5 wide-in-1536 third tick", tb_[2], 576);
    endtask

    task automatic t_clocked();
        step(1, 0, 0, 1);
        check("R2 first edge marks clocked", rxb_n, 1);
        for (int i = 0; i < 20; i++) step(((i / 2) % 2) == 0, 0, 0, 1);
        check("R4 clocked narrow -> 1536", mode_n, 0);
        check("R6 clocked wide -> 2048", mode_w, 2);
        step(sel, 0, 1, 0);
        clear_log();
        for (int i = 0; i < 520; i++) step(((i / 2) % 2) == 0, 0, 0, 1);
        check("R5 tick count 1536", na, 2);
        check("R5 first tick", ta[0], 192);
        check("R5 second tick", ta[1], 384);
        check("R6 tick count 2048", nb, 2);
        check("R6 first tick", tb_[0], 256);
        check("R6 second tick", tb_[1], 512);
    endtask

    task automatic t_release();
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(1, 0, 0, 1);
        for (int i = 0; i < WIN - 1; i++) step(1, 0, 0, 1);
        check("R3 still clocked at WIN-1", rxb_n, 1);
        step(1, 0, 0, 1);
        check("R3 static at WIN", rxb_n, 0);
        check("R4 static1 narrow -> 1536", mode_n, 0);
        check("R6 static1 wide -> 2048", mode_w, 2);
    endtask

    task automatic t_rx_mclk();
        for (int i = 0; i < 10; i++) step(1, i[0], 0, 1);
        check("R9 toggling rx pin owns", rxm_n, 1);
        check("R9 sel unaffected", rxb_n, 0);
        for (int i = 0; i < WIN - 1; i++) step(1, 1, 0, 1);
        check("R9 still own at WIN-1", rxm_n, 1);
        step(1, 1, 0, 1);
        check("R9 borrows tx at WIN", rxm_n, 0);
    endtask

    task automatic t_fsx_coincide();
        for (int i = 0; i < WIN + 2; i++) step(0, 1, 0, 1);
        check("R4 back to 1544", mode_n, 1);
        clear_log();
        step(0, 1, 1, 1);
        for (int i = 0; i < 199; i++) step(0, 1, 0, 1);
        check("R8 coincide tick count", na, 1);
        check("R8 shared pulse is pulse 1", ta[0], 192);
        check("R8 wide shared pulse", tb_[0], 192);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_static_low();
        t_1544_frames();
        t_clocked();
        t_release();
        t_rx_mclk();
        t_fsx_coincide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule